// File: doc/BRIEF.md
# Stationary-Frame Predictive Current Cost Evaluator

This block scores every switching state of a two-level three-phase inverter once per control sample. On a sample strobe it takes the three measured phase currents, the alpha-beta current reference and the DC link voltage, all signed fixed point. It maps the phase currents into the stationary alpha-beta frame and predicts the load current one sample ahead with a forward-Euler model for each of the eight candidate voltage vectors. For each candidate it reports the L1 distance between that prediction and the reference.

The two model coefficients are fixed at build time. The decay factor is 1 − R·Ts/L and the input gain is Ts/L, each scaled by 2^KF. For a 10 Ω, 10 mH load sampled every 50 µs these are 62259 and 328 with KF = 16. The reference for the next sample is taken to be the present reference, so no extrapolation is done. A downstream stage picks the cheapest state and drives the gates. The eight costs come out together, registered, with a valid flag.

All fixed-point rounding is floor, done as an arithmetic right shift by KF. Two scale constants are used: T3 = (2^KF + 1)/3, which is 21845 for KF = 16, and the parameter INV_ROOT3, which is 37837 for KF = 16.

Top module: `ab_pred_cost`

## Requirements
- R1: Frame mapping. al = floor((2·ia − ib − ic)·T3 / 2^KF) and be = floor((ib − ic)·INV_ROOT3 / 2^KF).
- R2: Voltage units. u = floor(vdc·T3 / 2^KF) and w = floor(vdc·INV_ROOT3 / 2^KF). The input terms are gu = floor(K2·u / 2^KF) and gw = floor(K2·w / 2^KF).
- R3: Cost slot k belongs to switching state Sk. Its bits {Sa,Sb,Sc} are, for k = 0..7: 000, 100, 110, 010, 011, 001, 101, 111. Its vector multipliers are ca = 2·Sa − Sb − Sc and cb = Sb − Sc.
- R4: Predictions. pa = floor(K1·al / 2^KF) + ca·gu and pb = floor(K1·be / 2^KF) + cb·gw.
- R5: cost[k] = |ref_al − pa| + |ref_be − pb|. It is unsigned, W+3 bits wide and never wraps.
- R6: The rising edge that samples smp_stb high is followed by two more rising edges. On the second of these, all eight costs load and cost_vld goes high for one cycle. cost_vld is low in every other cycle.
- R7: Strobes on consecutive cycles give results on consecutive cycles, in the same order.
- R8: Slots 0 and 7 (the two zero-vector states) always carry equal costs.
- R9: While rst_n is low, cost_vld is low and every cost is zero.
- R10: Between valid pulses the costs hold their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | Sample strobe; inputs are captured when it is high |
| ia | input | W | Phase a current, signed |
| ib | input | W | Phase b current, signed |
| ic | input | W | Phase c current, signed |
| ref_al | input | W | Alpha current reference, signed |
| ref_be | input | W | Beta current reference, signed |
| vdc | input | W | DC link voltage, signed |
| cost | output | 8×(W+3) | Cost per switching state, slot k for state Sk |
| cost_vld | output | 1 | High for one cycle when the costs are new |

## Verification
The bench builds the block with W = 8 and with KF, K1, K2 and INV_ROOT3 at their defaults. The narrow width lets a regular grid of 16 values per phase current, across all three phases, be swept against three DC link voltages. That includes the most negative and most positive codes, where the W+3 cost width is tightest. Zero link voltage makes all eight costs collapse to one value, and a burst of back-to-back strobes exercises the pipelined ordering.

// File: rtl/ab_pred_cost.sv
module ab_pred_cost #(
  parameter int W         = 16,
  parameter int KF        = 16,
  parameter int K1        = 62259,
  parameter int K2        = 328,
  parameter int INV_ROOT3 = 37837,
  localparam int CW       = W + 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  smp_stb,
  input  logic signed [W-1:0]   ia,
  input  logic signed [W-1:0]   ib,
  input  logic signed [W-1:0]   ic,
  input  logic signed [W-1:0]   ref_al,
  input  logic signed [W-1:0]   ref_be,
  input  logic signed [W-1:0]   vdc,
  output logic [7:0][CW-1:0]    cost,
  output logic                  cost_vld
);

  localparam int WP = W + KF + 6;
  localparam int T3 = (2**KF + 1) / 3;
  localparam logic [23:0] SWTAB = {3'b111, 3'b101, 3'b001, 3'b011,
                                   3'b010, 3'b110, 3'b100, 3'b000};

  typedef logic signed [WP-1:0] wide_t;

  wide_t n_al, n_be, n_u, n_w;
  wide_t s1_al, s1_be, s1_u, s1_w, s1_ra, s1_rb;
  wide_t s2_ka, s2_kb, s2_gu, s2_gw, s2_ra, s2_rb;
  logic  s1_v, s2_v;
  logic [7:0][CW-1:0] c_nx;

  assign n_al = ((WP'(ia) <<< 1) - WP'(ib) - WP'(ic)) * WP'(T3);
  assign n_be = (WP'(ib) - WP'(ic)) * WP'(INV_ROOT3);
  assign n_u  = WP'(vdc) * WP'(T3);
  assign n_w  = WP'(vdc) * WP'(INV_ROOT3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v  <= 1'b0;
      s1_al <= '0;
      s1_be <= '0;
      s1_u  <= '0;
      s1_w  <= '0;
      s1_ra <= '0;
      s1_rb <= '0;
    end else begin
      s1_v <= smp_stb;
      if (smp_stb) begin
        s1_al <= n_al >>> KF;
        s1_be <= n_be >>> KF;
        s1_u  <= n_u >>> KF;
        s1_w  <= n_w >>> KF;
        s1_ra <= WP'(ref_al);
        s1_rb <= WP'(ref_be);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_v  <= 1'b0;
      s2_ka <= '0;
      s2_kb <= '0;
      s2_gu <= '0;
      s2_gw <= '0;
      s2_ra <= '0;
      s2_rb <= '0;
    end else begin
      s2_v <= s1_v;
      if (s1_v) begin
        s2_ka <= (s1_al * WP'(K1)) >>> KF;
        s2_kb <= (s1_be * WP'(K1)) >>> KF;
        s2_gu <= (s1_u * WP'(K2)) >>> KF;
        s2_gw <= (s1_w * WP'(K2)) >>> KF;
        s2_ra <= s1_ra;
        s2_rb <= s1_rb;
      end
    end
  end

  for (genvar k = 0; k < 8; k++) begin : g_st
    localparam logic [2:0] SB = SWTAB[3*k +: 3];
    localparam int CA = 2 * int'(SB[2]) - int'(SB[1]) - int'(SB[0]);
    localparam int CB = int'(SB[1]) - int'(SB[0]);
    wide_t pa, pb, ea, eb, ma, mb;
    assign pa = s2_ka + s2_gu * WP'(CA);
    assign pb = s2_kb + s2_gw * WP'(CB);
    assign ea = s2_ra - pa;
    assign eb = s2_rb - pb;
    assign ma = ea[WP-1] ? -ea : ea;
    assign mb = eb[WP-1] ? -eb : eb;
    assign c_nx[k] = CW'(ma + mb);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cost     <= '0;
      cost_vld <= 1'b0;
    end else begin
      cost_vld <= s2_v;
      if (s2_v) cost <= c_nx;
    end
  end

endmodule

// File: rtl/ab_pred_cost_chk.sv
module ab_pred_cost_chk #(
  parameter int CW = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_stb,
  input logic [7:0][CW-1:0] cost,
  input logic              cost_vld
);

  a_r6_strobe_to_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $past(smp_stb, 3) |-> cost_vld);

  a_r6_valid_from_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    cost_vld |-> $past(smp_stb, 3));

  a_r8_zero_pair: assert property (@(posedge clk) disable iff (!rst_n)
    cost_vld |-> (cost[0] == cost[7]));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cost_vld |-> $stable(cost));

  a_r9_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (!cost_vld && cost == '0));

endmodule

bind ab_pred_cost ab_pred_cost_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .cost(cost), .cost_vld(cost_vld)
);

// File: tb/ab_pred_cost_bench.sv
`timescale 1ns/1ps
module ab_pred_cost_bench;
  localparam int W  = 8;
  localparam int CW = W + 3;
  localparam longint K1 = 62259;
  localparam longint K2 = 328;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_stb = 1'b0;
  logic signed [W-1:0] ia = '0, ib = '0, ic = '0, ref_al = '0, ref_be = '0, vdc = '0;
  logic [7:0][CW-1:0] cost;
  logic cost_vld;

  int n_chk = 0;
  int n_fail = 0;
  int tab [8] = '{0, 4, 6, 2, 3, 1, 5, 7};
  longint exp_q [16][8];

  always #2 clk = ~clk;

  ab_pred_cost #(.W(W)) u_ab_pred_cost (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb),
    .ia(ia), .ib(ib), .ic(ic), .ref_al(ref_al), .ref_be(ref_be), .vdc(vdc),
    .cost(cost), .cost_vld(cost_vld)
  );

  function automatic longint labs(longint x);
    return (x < 0) ? -x : x;
  endfunction

  // R1..R5 model, from the stated formulas
  function automatic longint model(longint a, longint b, longint c,
                                   longint ra, longint rb, longint vd, int k);
    longint al, be, u, w, gu, gw, ka, kb, pa, pb;
    int sa, sb, sc;
    al = ((2*a - b - c) * 21845) >>> 16;
    be = ((b - c) * 37837) >>> 16;
    u  = (vd * 21845) >>> 16;
    w  = (vd * 37837) >>> 16;
    gu = (K2 * u) >>> 16;
    gw = (K2 * w) >>> 16;
    ka = (K1 * al) >>> 16;
    kb = (K1 * be) >>> 16;
    sa = (tab[k] >> 2) & 1;
    sb = (tab[k] >> 1) & 1;
    sc = tab[k] & 1;
    pa = ka + longint'(2*sa - sb - sc) * gu;
    pb = kb + longint'(sb - sc) * gw;
    return labs(ra - pa) + labs(rb - pb);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic drive(int a, int b, int c, int ra, int rb, int vd);
    ia = W'(a); ib = W'(b); ic = W'(c);
    ref_al = W'(ra); ref_be = W'(rb); vdc = W'(vd);
  endtask

  task automatic run1(int a, int b, int c, int ra, int rb, int vd);
    logic [7:0][CW-1:0] snap;
    drive(a, b, c, ra, rb, vd);
    smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0;
    @(negedge clk);
    chk(cost_vld == 1'b0, "R6 early valid", cost_vld, 0);
    @(negedge clk);
    chk(cost_vld == 1'b1, "R6 valid at latency", cost_vld, 1);
    for (int k = 0; k < 8; k++) begin
      longint e;
      e = model(a, b, c, ra, rb, vd, k);
      chk(longint'(cost[k]) == e, "R1 R2 R3 R4 R5 cost", cost[k], e);
    end
    chk(cost[0] == cost[7], "R8 zero pair", cost[7], cost[0]);
    snap = cost;
    @(negedge clk);
    chk(cost_vld == 1'b0, "R6 single pulse", cost_vld, 0);
    chk(cost == snap, "R10 hold", cost[1], snap[1]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cost_vld == 1'b0, "R9 reset valid", cost_vld, 0);
    chk(cost == '0, "R9 reset cost", cost[0], 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: zero link voltage, all slots equal
    run1(40, -10, -30, 5, -7, 0);
    for (int k = 1; k < 8; k++)
      chk(cost[k] == cost[0], "R2 zero vdc equal", cost[k], cost[0]);

    // R5: extremes
    run1(-128, 127, 127, 127, -128, 127);
    run1(127, -128, -128, -128, 127, 127);

    // grid sweep, R1..R5
    for (int vi = 0; vi < 3; vi++) begin
      for (int a = -128; a <= 127; a += 17)
        for (int b = -128; b <= 127; b += 17)
          for (int c = -128; c <= 127; c += 17)
            run1(a, b, c, (a + c) / 2, (b - c) / 2, vi * 60 + (vi == 2 ? 7 : 0));
    end

    // R7: back-to-back strobes
    for (int t = 0; t < 11; t++) begin
      if (t >= 3) begin
        chk(cost_vld == 1'b1, "R7 burst valid", cost_vld, 1);
        for (int k = 0; k < 8; k++)
          chk(longint'(cost[k]) == exp_q[t-3][k], "R7 burst order", cost[k], exp_q[t-3][k]);
      end
      if (t < 8) begin
        int a, b, c, ra, rb, vd;
        a = t * 31 - 120; b = 100 - t * 27; c = (t * 13) % 90 - 45;
        ra = t * 9 - 30; rb = 60 - t * 11; vd = 20 + t * 13;
        drive(a, b, c, ra, rb, vd);
        for (int k = 0; k < 8; k++) exp_q[t][k] = model(a, b, c, ra, rb, vd, k);
        smp_stb = 1'b1;
      end else begin
        smp_stb = 1'b0;
      end
      @(negedge clk);
    end
    chk(cost_vld == 1'b0, "R7 burst end", cost_vld, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule